// File: doc/BRIEF.md
# Quadrature to Up/Down Pulse Converter

This block turns the two phase signals of an incremental encoder into two separate active-low pulse trains: one for forward counts and one for reverse counts. It is built to drive an external up/down counter. It also drives a level output that shows the direction of the latest count. A third active-low pulse output marks the index position, and it is emitted only at specific phase edges, so it lines up with the count pulses.

Every raw input first crosses into the clock domain through a synchroniser. The two phase inputs then pass through a digital debounce filter of programmable length. A pair of select pins sets the resolution to one, two or four counts per quadrature cycle. A programmable length sets the width of every output pulse in clock cycles.

Top module: `quad_pulse_conv`

## Requirements
- R1: Resolution is decoded from two pins, and `res_x2_n_i` has priority. When `res_x2_n_i`=0 the block counts both edges of A (x2). When `res_x2_n_i`=1, `res_x4_i`=0 counts only rising edges of A (x1), and `res_x4_i`=1 counts every single edge of A or B (x4).
- R2: A counted edge in the forward direction drives `up_n_o` low for exactly `pulse_len_i` cycles, and a value of 0 gives 1 cycle. Forward means A leads B: A rises while B is 0, B rises while A is 1, A falls while B is 1, or B falls while A is 0.
- R3: A counted edge in the reverse direction (B leads A) drives `dn_n_o` low with the same width rule.
- R4: `dir_up_o` goes to 1 after any legal forward edge and to 0 after any legal reverse edge, whatever the resolution. It holds its value between edges.
- R5: `idx_n_o` pulses low in two cases, whatever the resolution: when filtered A rises while the index input is 1 and B is 0, and when filtered B falls while the index input is 1 and A is 1.
- R6: A filtered phase level changes only after the synchronised input has differed from it on `filt_len_i` consecutive samples (0 counts as 1), so shorter glitches are dropped. A clean input change drives the output pulse low on the (`filt_len_i`+3)th rising clock edge after the change.
- R7: If filtered A and filtered B change in the same cycle, the transition is illegal. It produces no up, down or index pulse and leaves `dir_up_o` unchanged.
- R8: An event that arrives while its own output pulse is still low is dropped. It neither restarts nor extends that pulse.
- R9: While `rst_n` is 0, all three pulse outputs are 1 and `dir_up_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a_i | input | 1 | Raw phase A |
| enc_b_i | input | 1 | Raw phase B |
| enc_z_i | input | 1 | Raw index track |
| res_x2_n_i | input | 1 | Low selects x2 resolution |
| res_x4_i | input | 1 | With x2 not selected: 1 gives x4, 0 gives x1 |
| filt_len_i | input | FILT_W | Debounce length in samples |
| pulse_len_i | input | PW_W | Output pulse width in cycles |
| up_n_o | output | 1 | Active-low forward count pulse |
| dn_n_o | output | 1 | Active-low reverse count pulse |
| idx_n_o | output | 1 | Active-low index pulse |
| dir_up_o | output | 1 | Direction of the latest legal edge |

## Verification
The index pulse and the forward count pulse fall in the same cycle whenever A rises with B low and the index input held high. The bench provokes this by running full quadrature cycles in both directions with the index input raised, and it judges that `idx_n_o` falls on the same cycle edge as the count pulse, one index pulse per cycle. A second collision happens when a new count edge arrives while the previous pulse is still low. The bench spaces edges closer than the pulse width and expects the surplus events to vanish rather than stretch the pulse. A behavioural model compares all four outputs on every cycle as well.

// File: rtl/qpc_pkg.sv
`timescale 1ns/1ps
package qpc_pkg;
    typedef enum logic [1:0] {
        RES_X1 = 2'd0,
        RES_X2 = 2'd1,
        RES_X4 = 2'd2
    } res_mode_e;

    // x2 select (active low) wins over the x4/x1 select
    function automatic res_mode_e pick_mode(input logic x2_sel_n, input logic x4_sel);
        res_mode_e m;
        if (!x2_sel_n)   m = RES_X2;
        else if (x4_sel) m = RES_X4;
        else             m = RES_X1;
        return m;
    endfunction
endpackage

// File: rtl/qpc_filter.sv
`timescale 1ns/1ps
module qpc_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4,
    parameter bit USE_FILTER  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             lvl_o
);
    localparam int EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   lvl;
        logic [CNT_W-1:0]       cnt;
    } flt_st_t;

    flt_st_t          st_d, st_q;
    logic             samp;
    logic [EXT_W-1:0] need, run;

    always_comb begin
        st_d      = st_q;
        samp      = st_q.sync[SYNC_STAGES-1];
        need      = (len_i == '0) ? EXT_W'(1) : {1'b0, len_i};
        run       = {1'b0, st_q.cnt} + EXT_W'(1);
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], raw_i};
        if (!USE_FILTER) begin
            st_d.lvl = samp;
            st_d.cnt = '0;
        end else if (samp == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (run >= need) begin
            st_d.lvl = samp;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = run[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

    // R6
    filt_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o != $past(lvl_o)) |-> (lvl_o == $past(samp)));
endmodule

// File: rtl/qpc_decode.sv
`timescale 1ns/1ps
module qpc_decode
    import qpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      a_i,
    input  logic      b_i,
    input  logic      z_i,
    input  res_mode_e mode_i,
    output logic      up_ev_o,
    output logic      dn_ev_o,
    output logic      idx_ev_o,
    output logic      dir_up_o
);
    typedef struct packed {
        logic pa;
        logic pb;
        logic dir;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic    ea, eb, legal, fwd, qual, cnt_ev;

    always_comb begin
        st_d   = st_q;
        ea     = a_i ^ st_q.pa;
        eb     = b_i ^ st_q.pb;
        legal  = ea ^ eb;
        fwd    = ea ? (a_i ^ b_i) : ~(a_i ^ b_i);
        unique case (mode_i)
            RES_X1:  qual = ea & a_i;
            RES_X2:  qual = ea;
            default: qual = 1'b1;
        endcase
        cnt_ev   = legal & qual;
        up_ev_o  = cnt_ev & fwd;
        dn_ev_o  = cnt_ev & ~fwd;
        idx_ev_o = legal & z_i & ((ea & a_i & ~b_i) | (eb & ~b_i & a_i));
        st_d.pa  = a_i;
        st_d.pb  = b_i;
        if (legal) st_d.dir = fwd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pa: 1'b0, pb: 1'b0, dir: 1'b1};
        else        st_q <= st_d;
    end

    assign dir_up_o = st_q.dir;

    // R7
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ea && eb) |=> (dir_up_o == $past(dir_up_o)));
    // R4
    dir_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_ev_o |=> dir_up_o);
    // R4
    dir_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_ev_o |=> !dir_up_o);
endmodule

// File: rtl/qpc_pulse.sv
`timescale 1ns/1ps
module qpc_pulse #(
    parameter int PW_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_i,
    input  logic [PW_W-1:0] len_i,
    output logic            pulse_n_o
);
    typedef struct packed {
        logic [PW_W-1:0] cnt;
    } pls_st_t;

    pls_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - PW_W'(1);
        else if (trig_i)
            st_d.cnt = (len_i == '0) ? PW_W'(1) : len_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_n_o = (st_q.cnt == '0);

    // R2
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_n_o) |-> $past(trig_i));
    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && st_q.cnt > PW_W'(1)) |=> !pulse_n_o);
endmodule

// File: rtl/quad_pulse_conv.sv
`timescale 1ns/1ps
module quad_pulse_conv
    import qpc_pkg::*;
#(
    parameter int FILT_W      = 4,
    parameter int PW_W        = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a_i,
    input  logic              enc_b_i,
    input  logic              enc_z_i,
    input  logic              res_x2_n_i,
    input  logic              res_x4_i,
    input  logic [FILT_W-1:0] filt_len_i,
    input  logic [PW_W-1:0]   pulse_len_i,
    output logic              up_n_o,
    output logic              dn_n_o,
    output logic              idx_n_o,
    output logic              dir_up_o
);
    localparam int N_IN  = 3;   // A, B, index
    localparam int N_OUT = 3;   // up, down, index

    logic [N_IN-1:0]  raw, lvl;
    logic [N_OUT-1:0] evs, outs_n;
    res_mode_e        mode;

    assign raw  = {enc_z_i, enc_b_i, enc_a_i};
    assign mode = pick_mode(res_x2_n_i, res_x4_i);

    generate
        for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
            qpc_filter #(
                .SYNC_STAGES(SYNC_STAGES),
                .CNT_W      (FILT_W),
                .USE_FILTER (gi != N_IN - 1)
            ) u_filt (
                .clk  (clk),
                .rst_n(rst_n),
                .raw_i(raw[gi]),
                .len_i(filt_len_i),
                .lvl_o(lvl[gi])
            );
        end
    endgenerate

    qpc_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_i     (lvl[0]),
        .b_i     (lvl[1]),
        .z_i     (lvl[2]),
        .mode_i  (mode),
        .up_ev_o (evs[0]),
        .dn_ev_o (evs[1]),
        .idx_ev_o(evs[2]),
        .dir_up_o(dir_up_o)
    );

    generate
        for (genvar go = 0; go < N_OUT; go++) begin : g_out
            qpc_pulse #(.PW_W(PW_W)) u_pls (
                .clk      (clk),
                .rst_n    (rst_n),
                .trig_i   (evs[go]),
                .len_i    (pulse_len_i),
                .pulse_n_o(outs_n[go])
            );
        end
    endgenerate

    assign up_n_o  = outs_n[0];
    assign dn_n_o  = outs_n[1];
    assign idx_n_o = outs_n[2];
endmodule

// File: tb/quad_pulse_conv_tb_top.sv
`timescale 1ns/1ps
module quad_pulse_conv_tb_top;
    localparam int FW = 4;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_r = 1'b0, b_r = 1'b0, z_r = 1'b0;
    logic          x2_n = 1'b1, x4 = 1'b1;
    logic [FW-1:0] filt_len = FW'(3);
    logic [PW-1:0] pulse_len = PW'(4);
    logic          up_n, dn_n, idx_n, dir_up;

    int checks = 0, errors = 0;
    int up_cnt = 0, dn_cnt = 0, idx_cnt = 0;
    logic pu = 1'b1, pd = 1'b1, pi = 1'b1;
    bit done = 1'b0;

    always #5 clk = ~clk;

    quad_pulse_conv #(.FILT_W(FW), .PW_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .enc_a_i(a_r), .enc_b_i(b_r), .enc_z_i(z_r),
        .res_x2_n_i(x2_n), .res_x4_i(x4), .filt_len_i(filt_len), .pulse_len_i(pulse_len),
        .up_n_o(up_n), .dn_n_o(dn_n), .idx_n_o(idx_n), .dir_up_o(dir_up));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, one update per rising edge
    int m_s1[3], m_s2[3], m_lv[3], m_ct[3], m_cu[3];
    int m_pa = 0, m_pb = 0, m_dir = 1;

    always @(posedge clk) begin : ref_model
        int nf, np, ea, eb, lg, fw, q, eu, ed, ei;
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin
                m_s1[k] = 0; m_s2[k] = 0; m_lv[k] = 0; m_ct[k] = 0; m_cu[k] = 0;
            end
            m_pa = 0; m_pb = 0; m_dir = 1;
        end else begin
            nf = (filt_len == 0) ? 1 : int'(filt_len);
            np = (pulse_len == 0) ? 1 : int'(pulse_len);
            ea = int'(m_lv[0] != m_pa);
            eb = int'(m_lv[1] != m_pb);
            lg = int'(ea != eb);
            fw = (ea != 0) ? int'(m_lv[0] != m_lv[1]) : int'(m_lv[0] == m_lv[1]);
            if (!x2_n)   q = ea;
            else if (x4) q = 1;
            else         q = int'(ea != 0 && m_lv[0] != 0);
            eu = int'(lg != 0 && q != 0 && fw != 0);
            ed = int'(lg != 0 && q != 0 && fw == 0);
            ei = int'(lg != 0 && m_lv[2] != 0 &&
                      ((ea != 0 && m_lv[0] != 0 && m_lv[1] == 0) ||
                       (eb != 0 && m_lv[1] == 0 && m_lv[0] != 0)));
            for (int k = 0; k < 3; k++) begin
                int ev;
                ev = (k == 0) ? eu : ((k == 1) ? ed : ei);
                if (m_cu[k] > 0)   m_cu[k]--;
                else if (ev != 0)  m_cu[k] = np;
            end
            if (lg != 0) m_dir = fw;
            m_pa = m_lv[0];
            m_pb = m_lv[1];
            for (int k = 0; k < 2; k++) begin
                if (m_s2[k] == m_lv[k]) m_ct[k] = 0;
                else if (m_ct[k] + 1 >= nf) begin m_lv[k] = m_s2[k]; m_ct[k] = 0; end
                else m_ct[k]++;
            end
            m_lv[2] = m_s2[2];
            for (int k = 0; k < 3; k++) m_s2[k] = m_s1[k];
            m_s1[0] = int'(a_r); m_s1[1] = int'(b_r); m_s1[2] = int'(z_r);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(up_n == (m_cu[0] == 0), "R2 model up_n", int'(up_n), int'(m_cu[0] == 0));
            chk(dn_n == (m_cu[1] == 0), "R3 model dn_n", int'(dn_n), int'(m_cu[1] == 0));
            chk(idx_n == (m_cu[2] == 0), "R5 model idx_n", int'(idx_n), int'(m_cu[2] == 0));
            chk(int'(dir_up) == m_dir, "R4 model dir_up", int'(dir_up), m_dir);
        end
        if (pu && !up_n) up_cnt++;
        if (pd && !dn_n) dn_cnt++;
        if (pi && !idx_n) idx_cnt++;
        pu = up_n; pd = dn_n; pi = idx_n;
    end

    task automatic step(input logic a, input logic b, input int gap);
        @(negedge clk);
        a_r = a; b_r = b;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic fwd(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            step(1, 0, gap); step(1, 1, gap); step(0, 1, gap); step(0, 0, gap);
        end
    endtask

    task automatic rev(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            step(0, 1, gap); step(1, 1, gap); step(1, 0, gap); step(0, 0, gap);
        end
    endtask

    task automatic clr();
        up_cnt = 0; dn_cnt = 0; idx_cnt = 0;
    endtask

    initial begin
        int n, w;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(up_n && dn_n && idx_n, "R9 pulses idle in reset", int'({up_n, dn_n, idx_n}), 7);
        chk(dir_up == 1'b1, "R9 dir in reset", int'(dir_up), 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R6 latency and R2 width, x4 mode
        clr();
        a_r = 1'b1; n = 0;
        do begin @(negedge clk); n++; end while (up_n && n < 50);
        chk(n == 6, "R6 latency filt 3", n, 6);
        w = 0;
        while (!up_n && w < 50) begin @(negedge clk); w++; end
        chk(w == 4, "R2 pulse width 4", w, 4);
        step(1, 1, 12); step(0, 1, 12); step(0, 0, 12);
        clr();

        // R1/R2 x4 forward
        fwd(3, 12);
        chk(up_cnt == 12, "R1 R2 x4 forward ups", up_cnt, 12);
        chk(dn_cnt == 0, "R2 x4 forward no downs", dn_cnt, 0);
        chk(dir_up == 1'b1, "R4 dir after forward", int'(dir_up), 1);
        clr();
        // R3/R4 x4 reverse
        rev(2, 12);
        chk(dn_cnt == 8, "R3 x4 reverse downs", dn_cnt, 8);
        chk(up_cnt == 0, "R3 x4 reverse no ups", up_cnt, 0);
        chk(dir_up == 1'b0, "R4 dir after reverse", int'(dir_up), 0);
        clr();

        // R1 x2 (priority over x4 select)
        x2_n = 1'b0; x4 = 1'b1;
        fwd(2, 12);
        chk(up_cnt == 4, "R1 x2 forward ups", up_cnt, 4);
        clr();
        // R1 x1
        x2_n = 1'b1; x4 = 1'b0;
        fwd(2, 12);
        chk(up_cnt == 2, "R1 x1 forward ups", up_cnt, 2);
        clr();
        rev(2, 12);
        chk(dn_cnt == 2, "R1 x1 reverse downs", dn_cnt, 2);
        chk(up_cnt == 0, "R1 x1 reverse no ups", up_cnt, 0);
        clr();

        // R5 index with count pulse in same cycle
        x4 = 1'b1; z_r = 1'b1;
        repeat (6) @(negedge clk);
        fwd(1, 12);
        rev(1, 12);
        chk(idx_cnt == 2, "R5 index one per cycle", idx_cnt, 2);
        z_r = 1'b0;
        repeat (6) @(negedge clk);
        clr();
        fwd(1, 12);
        chk(idx_cnt == 0, "R5 index low gives none", idx_cnt, 0);
        clr();

        // R6 glitch shorter than filter length
        step(1, 0, 2); step(0, 0, 14);
        chk(up_cnt + dn_cnt == 0, "R6 glitch dropped", up_cnt + dn_cnt, 0);
        // R7 both phases change together
        step(1, 1, 14);
        chk(up_cnt + dn_cnt == 0, "R7 illegal no pulse", up_cnt + dn_cnt, 0);
        chk(dir_up == 1'b1, "R7 dir kept", int'(dir_up), 1);
        step(0, 0, 14);
        chk(up_cnt + dn_cnt == 0, "R7 illegal back no pulse", up_cnt + dn_cnt, 0);
        clr();

        // R8 events while pulse active are dropped
        pulse_len = PW'(10);
        fwd(1, 4);
        repeat (20) @(negedge clk);
        chk(up_cnt == 2, "R8 busy edges dropped", up_cnt, 2);
        // R2 zero width acts as one
        pulse_len = PW'(0);
        repeat (4) @(negedge clk);
        clr();
        fwd(1, 12);
        chk(up_cnt == 4, "R2 width zero ups", up_cnt, 4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500us;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule